// File: doc/BRIEF.md
# Triggered Multichannel Pipeline Capture Buffer

This block sits behind a bank of sixteen 14-bit ADC streams that share one sample clock. Every clock, the samples of all channels go as one wide word into a circular ring memory, so the recent past of every channel stays available. When a trigger is accepted, the block rewinds by a programmable number of samples. It then copies a 64-sample window from every channel into an output FIFO, as one packed event. The rewind lets the captured window line up with the physical pulse, even though the trigger decision arrives several microseconds later.

The trigger comes from one of two sources, picked by `self_mode`. With `self_mode` low, it is the rising edge of an external system trigger. With `self_mode` high, it is a local threshold trigger, which fires when any enabled channel rises above a programmable level. Only one event is built at a time. A trigger that arrives while an event is being built is dropped and counted. A trigger that arrives while the output FIFO is filled beyond its almost-full level is also dropped and counted. Readout uses a show-ahead FIFO port.

The controller has four states. IDLE waits for a trigger. HEADER writes the event header word. READ issues 1024 ring reads, channel-major. FLUSH writes the last sample word. The transitions are:
- IDLE to HEADER on an accepted trigger.
- HEADER to READ unconditionally.
- READ to FLUSH after the last window read is issued.
- FLUSH to IDLE unconditionally.

Top module: `capture_buffer`

## Requirements
- R1: After reset, `rd_valid`, `busy` and `drop_cnt` are 0. The header of the first event carries event number 0.
- R2: The sample presented in the n-th clock after reset release is stored at ring slot n mod RING_DEPTH. Capture windows that cross the end of the ring read the correct samples on both sides of the wrap.
- R3: An event window starts at sample (t − `delay`), where t is the sample presented in the clock that accepts the trigger. `delay` may be any value from 0 up to RING_DEPTH − NCH·WIN − 8, which is 3064 at the default parameters.
- R4: Each event is exactly 1 + NCH·WIN words of 17 bits. Word 0 is the header, with bit 16 = 1. Each data word is {1'b0, 2'b00, sample[13:0]}. Data words run from channel 0 to channel 15, and each channel gives its 64 consecutive samples oldest first.
- R5: With `self_mode` = 0, only a rising edge of `ext_trig` triggers. A level held high for many clocks gives exactly one event.
- R6: With `self_mode` = 1, a trigger fires in the clock where at least one channel whose `chan_en` bit is set shows a sample strictly greater than `thresh`, provided no enabled channel did so in the previous sample. Disabled channels, samples equal to `thresh`, and `ext_trig` have no effect.
- R7: A trigger that arrives outside IDLE creates no event and increments `drop_cnt` by one.
- R8: `busy` is high exactly when the FIFO holds more than `afull_lvl` words. A trigger seen while `busy` is high is refused and increments `drop_cnt`.
- R9: The header's low 16 bits hold the event number. The event number rises by one per accepted trigger and does not advance on dropped triggers.
- R10: `rd_valid` is high whenever the FIFO is non-empty, and `rd_data` then shows the oldest word. A clock with `rd_en` high pops that word. The FIFO never takes a write while full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_data | input | NCH*SW | All channel samples, channel i at bits [i*SW +: SW] |
| ext_trig | input | 1 | External system trigger (rising edge) |
| self_mode | input | 1 | 1 selects the threshold trigger, 0 selects the external trigger |
| chan_en | input | NCH | Per-channel enable for the threshold trigger |
| thresh | input | SW | Threshold level for the self-trigger |
| delay | input | log2(RING_DEPTH) | Rewind from the trigger sample to the window start |
| afull_lvl | input | log2(FIFO_DEPTH)+1 | FIFO almost-full level |
| rd_en | input | 1 | Pop the oldest FIFO word |
| rd_data | output | 17 | Oldest FIFO word (show-ahead) |
| rd_valid | output | 1 | FIFO not empty |
| busy | output | 1 | FIFO level above `afull_lvl` |
| drop_cnt | output | 16 | Count of refused triggers |

## Verification
A corrupted window-start register or a bad read pointer shows up as wrong data words in the next event. The first wrong word appears about two clocks after the header, for the channel-0 samples. A slip in the channel index shows up at the first channel boundary, 64 words into the event. A wrong trigger-acceptance state shows up either as a missing or extra event, which is visible after about 1030 clocks, or as a `drop_cnt` step on the clock after the trigger. A wrong FIFO level shows up at once on `busy` and `rd_valid`.

// File: rtl/cap_pkg.sv
package cap_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_HDR,
        S_RD,
        S_FLUSH
    } cap_state_t;

    localparam int EVT_W = 16;
    localparam int OUT_W = EVT_W + 1;
endpackage

// File: rtl/trig_detect.sv
module trig_detect #(
    parameter int NCH = 16,
    parameter int SW  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH*SW-1:0] adc_data,
    input  logic              ext_trig,
    input  logic              self_mode,
    input  logic [NCH-1:0]    chan_en,
    input  logic [SW-1:0]     thresh,
    output logic              trig_pulse
);
    logic [NCH-1:0] over;
    logic           any_over;
    logic           any_q;
    logic           ext_q;

    // One comparator per channel.
    for (genvar i = 0; i < NCH; i++) begin : g_cmp
        assign over[i] = chan_en[i] && (adc_data[i*SW +: SW] > thresh);
    end

    assign any_over = |over;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            any_q <= 1'b0;
            ext_q <= 1'b0;
        end else begin
            any_q <= any_over;
            ext_q <= ext_trig;
        end
    end

    // Rising edge of whichever source is selected.
    assign trig_pulse = self_mode ? (any_over && !any_q) : (ext_trig && !ext_q);
endmodule

// File: rtl/sample_ring.sv
module sample_ring #(
    parameter int W     = 224,
    parameter int DEPTH = 4096
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [W-1:0]             wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [$clog2(DEPTH)-1:0] wr_ptr,
    output logic [W-1:0]             rd_q
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];

    // Write pointer advances every clock and wraps at the ring depth.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wr_ptr <= '0;
        else        wr_ptr <= wr_ptr + AW'(1);
    end

    always_ff @(posedge clk) begin
        mem[wr_ptr] <= wr_data;
        rd_q        <= mem[rd_addr];
    end
endmodule

// File: rtl/evt_fifo.sv
module evt_fifo #(
    parameter int W     = 17,
    parameter int DEPTH = 2048
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   push,
    input  logic [W-1:0]           din,
    input  logic                   pop,
    output logic [W-1:0]           dout,
    output logic                   empty,
    output logic                   full,
    output logic [$clog2(DEPTH):0] level
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp;
    logic [AW-1:0] rp;
    logic          do_push;
    logic          do_pop;

    assign empty   = (level == '0);
    assign full    = (level == (AW+1)'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= wp + AW'(1);
            if (do_pop)  rp <= rp + AW'(1);
            unique case ({do_push, do_pop})
                2'b10:   level <= level + (AW+1)'(1);
                2'b01:   level <= level - (AW+1)'(1);
                default: level <= level;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end
endmodule

// File: rtl/capture_buffer.sv
module capture_buffer
    import cap_pkg::*;
#(
    parameter int NCH        = 16,
    parameter int SW         = 14,
    parameter int RING_DEPTH = 4096,
    parameter int WIN        = 64,
    parameter int FIFO_DEPTH = 2048
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NCH*SW-1:0]             adc_data,
    input  logic                          ext_trig,
    input  logic                          self_mode,
    input  logic [NCH-1:0]                chan_en,
    input  logic [SW-1:0]                 thresh,
    input  logic [$clog2(RING_DEPTH)-1:0] delay,
    input  logic [$clog2(FIFO_DEPTH):0]   afull_lvl,
    input  logic                          rd_en,
    output logic [OUT_W-1:0]              rd_data,
    output logic                          rd_valid,
    output logic                          busy,
    output logic [15:0]                   drop_cnt
);
    localparam int RAW  = $clog2(RING_DEPTH);
    localparam int WAW  = $clog2(WIN);
    localparam int CAW  = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int IDXW = CAW + WAW;
    localparam int LVW  = $clog2(FIFO_DEPTH) + 1;
    localparam int PADW = OUT_W - 1 - SW;

    cap_state_t      state;
    cap_state_t      nstate;
    logic            trig;
    logic            accept;
    logic            push_hdr;
    logic            issue;
    logic            rd_last;
    logic [RAW-1:0]  wr_ptr;
    logic [RAW-1:0]  start_q;
    logic [RAW-1:0]  ring_addr;
    logic [IDXW-1:0] rd_idx;
    logic [WAW-1:0]  s_idx;
    logic [CAW-1:0]  c_idx;
    logic [CAW-1:0]  sel_q;
    logic            rvalid_q;
    logic [NCH*SW-1:0] ring_q;
    logic [SW-1:0]   word;
    logic [EVT_W-1:0] evt_cnt;
    logic            fifo_push;
    logic [OUT_W-1:0] fifo_din;
    logic            fifo_empty;
    logic            fifo_full;
    logic [LVW-1:0]  fifo_level;

    trig_detect #(.NCH(NCH), .SW(SW)) u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .adc_data   (adc_data),
        .ext_trig   (ext_trig),
        .self_mode  (self_mode),
        .chan_en    (chan_en),
        .thresh     (thresh),
        .trig_pulse (trig)
    );

    assign s_idx     = rd_idx[WAW-1:0];
    assign c_idx     = CAW'(rd_idx >> WAW);
    assign rd_last   = &rd_idx;
    assign ring_addr = start_q + RAW'(s_idx);

    sample_ring #(.W(NCH*SW), .DEPTH(RING_DEPTH)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_data (adc_data),
        .rd_addr (ring_addr),
        .wr_ptr  (wr_ptr),
        .rd_q    (ring_q)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    // Next state and per-state strobes.
    always_comb begin
        nstate   = state;
        accept   = 1'b0;
        push_hdr = 1'b0;
        issue    = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (trig && !busy) begin
                    accept = 1'b1;
                    nstate = S_HDR;
                end
            end
            S_HDR: begin
                push_hdr = 1'b1;
                nstate   = S_RD;
            end
            S_RD: begin
                issue = 1'b1;
                if (rd_last) nstate = S_FLUSH;
            end
            S_FLUSH: nstate = S_IDLE;
            default: nstate = S_IDLE;
        endcase
    end

    // Capture datapath.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q  <= '0;
            rd_idx   <= '0;
            sel_q    <= '0;
            rvalid_q <= 1'b0;
            evt_cnt  <= '0;
            drop_cnt <= '0;
        end else begin
            if (accept)   start_q <= wr_ptr - delay;
            if (push_hdr) begin
                rd_idx  <= '0;
                evt_cnt <= evt_cnt + EVT_W'(1);
            end else if (issue) begin
                rd_idx <= rd_idx + IDXW'(1);
            end
            rvalid_q <= issue;
            sel_q    <= c_idx;
            if (trig && !accept) drop_cnt <= drop_cnt + 16'd1;
        end
    end

    assign word      = ring_q[sel_q*SW +: SW];
    assign fifo_push = push_hdr || rvalid_q;
    assign fifo_din  = push_hdr ? {1'b1, evt_cnt} : {1'b0, {PADW{1'b0}}, word};

    evt_fifo #(.W(OUT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_push),
        .din   (fifo_din),
        .pop   (rd_en),
        .dout  (rd_data),
        .empty (fifo_empty),
        .full  (fifo_full),
        .level (fifo_level)
    );

    assign rd_valid = !fifo_empty;
    assign busy     = (fifo_level > afull_lvl);
endmodule

// File: rtl/cap_chk.sv
module cap_chk
    import cap_pkg::*;
#(
    parameter int IW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input cap_state_t    state,
    input logic          busy,
    input logic          trig,
    input logic [15:0]   drop_cnt,
    input logic          fifo_push,
    input logic          fifo_full,
    input logic [IW-1:0] rd_idx
);
    // R4
    hdr_then_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_HDR |=> state == S_RD);

    // R4
    read_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RD && $past(state) == S_RD) |-> rd_idx == $past(rd_idx) + IW'(1));

    // R8
    accept_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_HDR |-> ($past(state) == S_IDLE && !$past(busy)));

    // R7
    single_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_cnt != $past(drop_cnt) |-> (drop_cnt == $past(drop_cnt) + 16'd1 && $past(trig)));

    // R5
    trig_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> !trig);

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> !fifo_full);
endmodule

bind capture_buffer cap_chk #(.IW(IDXW)) u_cap_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .busy      (busy),
    .trig      (trig),
    .drop_cnt  (drop_cnt),
    .fifo_push (fifo_push),
    .fifo_full (fifo_full),
    .rd_idx    (rd_idx)
);

// File: tb/tb_capture_buffer.sv
module tb_capture_buffer;
    localparam int NCH  = 16;
    localparam int SW   = 14;
    localparam int DEP  = 4096;
    localparam int WIN  = 64;
    localparam int FDEP = 2048;
    localparam int DMAX = DEP - NCH*WIN - 8;
    localparam int NWORDS = 1 + NCH*WIN;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NCH*SW-1:0] adc_data;
    logic              ext_trig;
    logic              self_mode;
    logic [NCH-1:0]    chan_en;
    logic [SW-1:0]     thresh;
    logic [11:0]       delay;
    logic [11:0]       afull_lvl;
    logic              rd_en;
    logic [16:0]       rd_data;
    logic              rd_valid;
    logic              busy;
    logic [15:0]       drop_cnt;

    int errors = 0;
    int checks = 0;
    int sn     = 0;
    int cur_n  = -1;
    int ev     = 0;
    bit done   = 1'b0;

    int sp_n  [32];
    int sp_ch [32];
    int sp_v  [32];
    int sp_cnt = 0;

    always #10 clk = ~clk;

    capture_buffer dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .adc_data  (adc_data),
        .ext_trig  (ext_trig),
        .self_mode (self_mode),
        .chan_en   (chan_en),
        .thresh    (thresh),
        .delay     (delay),
        .afull_lvl (afull_lvl),
        .rd_en     (rd_en),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .busy      (busy),
        .drop_cnt  (drop_cnt)
    );

    function automatic int smp(input int n, input int ch);
        int unsigned h;
        for (int k = 0; k < sp_cnt; k++)
            if (sp_n[k] == n && sp_ch[k] == ch) return sp_v[k];
        h = (int'(n) * 32'd1103515245) + (ch * 32'd12345) + 32'd7;
        return int'((h >> 9) & 32'hFFF);
    endfunction

    function automatic logic [NCH*SW-1:0] pack(input int n);
        logic [NCH*SW-1:0] v;
        for (int ch = 0; ch < NCH; ch++) v[ch*SW +: SW] = SW'(smp(n, ch));
        return v;
    endfunction

    // Sample source: sample n is presented in the n-th clock after reset release.
    always @(negedge clk) begin
        if (rst_n) begin
            adc_data <= pack(sn);
            cur_n    <= sn;
            sn       <= sn + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic add_spike(input int n, input int ch, input int v, input int len);
        for (int k = 0; k < len; k++) begin
            sp_n[sp_cnt]  = n + k;
            sp_ch[sp_cnt] = ch;
            sp_v[sp_cnt]  = v;
            sp_cnt++;
        end
    endtask

    task automatic wait_n(input int t);
        while (cur_n < t) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic fire(input int hold, output int tn);
        @(negedge clk); #1;
        ext_trig = 1'b1;
        tn = cur_n;
        repeat (hold) @(negedge clk);
        #1 ext_trig = 1'b0;
    endtask

    // Drains one event, checks the header (R9) and the body.
    task automatic expect_event(input int tn, input int d, input string req);
        int bad = 0;
        int fa = 0;
        int fe = 0;
        int hdr = 0;
        int e;
        for (int w = 0; w < NWORDS; w++) begin
            rd_en = 1'b0;
            while (!rd_valid) begin
                @(negedge clk); #1;
            end
            if (w == 0) begin
                hdr = int'(rd_data);
            end else begin
                e = smp(tn - d + ((w-1) % WIN), (w-1) / WIN);
                if (int'(rd_data) != e) begin
                    if (bad == 0) begin
                        fa = int'(rd_data);
                        fe = e;
                    end
                    bad++;
                end
            end
            rd_en = 1'b1;
            @(negedge clk); #1;
        end
        rd_en = 1'b0;
        chk(hdr == (32'h10000 | (ev & 32'hFFFF)), "R9", "header word", hdr,
            32'h10000 | (ev & 32'hFFFF));
        chk(bad == 0, req, "window data (first bad word)", fa, fe);
        ev++;
    endtask

    task automatic quiet(input string req);
        repeat (1200) @(negedge clk);
        #1;
        chk(rd_valid == 1'b0, req, "no extra event rd_valid", int'(rd_valid), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int tn;
        int d;
        int dc;
        int tgt;
        int ch;
        void'($urandom(32'h5EED));
        rst_n     = 1'b0;
        adc_data  = '0;
        ext_trig  = 1'b0;
        self_mode = 1'b0;
        chan_en   = '1;
        thresh    = 14'h1800;
        delay     = 12'd10;
        afull_lvl = 12'd1500;
        rd_en     = 1'b0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;

        // R1 reset state
        chk(rd_valid == 1'b0, "R1", "rd_valid after reset", int'(rd_valid), 0);
        chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
        chk(drop_cnt == 16'd0, "R1", "drop_cnt after reset", int'(drop_cnt), 0);

        // R3 / R1 first event, then delay 0 and maximum delay
        wait_n(300);
        delay = 12'd10;
        fire(1, tn);
        expect_event(tn, 10, "R3");
        delay = 12'd0;
        fire(1, tn);
        expect_event(tn, 0, "R3");
        wait_n(DMAX + 200);
        delay = 12'(DMAX);
        fire(1, tn);
        expect_event(tn, DMAX, "R3");

        // R5 level held high gives one event
        delay = 12'd20;
        fire(25, tn);
        expect_event(tn, 20, "R5");
        quiet("R5");

        // R7 trigger during readout is dropped
        fire(1, tn);
        repeat (40) @(negedge clk);
        fire(1, d);
        expect_event(tn, 20, "R4");
        quiet("R7");
        chk(drop_cnt == 16'd1, "R7", "drop_cnt", int'(drop_cnt), 1);

        // R8 busy refusal
        afull_lvl = 12'd100;
        fire(1, tn);
        repeat (1100) @(negedge clk);
        #1;
        chk(busy == 1'b1, "R8", "busy with full event", int'(busy), 1);
        fire(1, d);
        repeat (3) @(negedge clk);
        #1;
        chk(drop_cnt == 16'd2, "R8", "drop_cnt after refusal", int'(drop_cnt), 2);
        expect_event(tn, 20, "R10");
        chk(busy == 1'b0, "R8", "busy after drain", int'(busy), 0);
        quiet("R8");
        afull_lvl = 12'd1500;

        // R3 random delays and gaps
        for (int i = 0; i < 6; i++) begin
            d = $urandom_range(0, DMAX);
            delay = 12'(d);
            repeat ($urandom_range(1, 200)) @(negedge clk);
            fire(1, tn);
            expect_event(tn, d, "R3");
        end

        // R2 window straddling the ring end
        tgt = cur_n + 1 + (((DEP - 20 + DMAX) - (cur_n + 1)) % DEP + DEP) % DEP;
        delay = 12'(DMAX);
        wait_n(tgt - 1);
        fire(1, tn);
        chk(tn == tgt, "R2", "trigger sample", tn, tgt);
        expect_event(tn, DMAX, "R2");

        // R6 self-trigger mode
        self_mode = 1'b1;
        chan_en   = ~(16'h1 << 5);
        delay     = 12'd40;
        @(negedge clk); #1;
        dc = int'(drop_cnt);
        add_spike(cur_n + 30, 5, 14'h3FFF, 1);
        quiet("R6");
        chk(int'(drop_cnt) == dc, "R6", "disabled channel drop_cnt", int'(drop_cnt), dc);
        fire(1, d);
        quiet("R6");
        add_spike(cur_n + 30, 3, 14'h1800, 2);
        quiet("R6");
        add_spike(cur_n + 30, 9, 14'h2A00, 3);
        expect_event(cur_n + 30, 40, "R6");
        quiet("R6");
        for (int i = 0; i < 3; i++) begin
            ch = $urandom_range(0, NCH-1);
            if (ch == 5) ch = 6;
            d = $urandom_range(0, DMAX);
            delay = 12'(d);
            @(negedge clk); #1;
            tn = cur_n + 20 + $urandom_range(0, 100);
            add_spike(tn, ch, $urandom_range(14'h1801, 14'h3FFF), 1);
            expect_event(tn, d, "R6");
        end
        chk(int'(drop_cnt) == dc, "R7", "no drops in self tests", int'(drop_cnt), dc);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule